// File: doc/BRIEF.md
# Predicate Mask Register File

This block holds thirty-two predicate masks for a vector unit that is organised as 8 sublanes by a parameterised number of lanes. Each mask has one activity bit per (sublane, lane) cell. A consumer reads a mask through a single combinational read port that can name any of the thirty-two entries. A producer loads a mask through a single write port that can reach only the lower sixteen entries.

The write port builds the new mask from one of five sources:

- a rectangle decoded from a packed 32-bit bounds word;
- a uniform fill of all ones or all zeros;
- an 8-bit per-sublane pattern;
- the AND of two stored masks;
- the complement of one stored mask.

Both ports take the architectural register id, which is the entry index plus 0x5F. The block checks each id against the band its port is allowed to use. A read id outside its band is flagged. A write that is outside its band, or that carries an unknown operation, is refused and flagged, and the file is left as it was.

Top module: `pred_mask_file`

## Requirements
- R1: Synchronous active-high reset clears all 32 entries to zero. Every legal read that follows returns all zeros until a write lands.
- R2: A read id in 0x5F..0x7E returns entry (id − 0x5F) on `rd_mask` in the same cycle, with `rd_illegal` low. Any other id drives `rd_illegal` high and `rd_mask` to zero.
- R3: A write id in 0x5F..0x6E is legal. When `wr_en` is high and the id is outside that band, `wr_err` is high in that cycle and no entry changes.
- R4: An accepted write updates its entry at the next rising clock edge. A read of the same entry in the cycle of the write returns the old contents.
- R5: Mask bit s·LANES + l belongs to sublane s (0..7) and lane l (0..LANES−1), for every source.
- R6: Operation code 0 (rectangle) decodes `wr_imm` as follows: sublane low in [2:0], lane low in [9:3], sublane high in [12:10], lane high in [19:13]. Both high bounds are inclusive. A cell is set when low ≤ index ≤ high on both axes. A low bound above its high bound gives an empty mask, and lane bounds at or beyond LANES select no extra lanes.
- R7: Operation code 1 (fill) sets every bit of the destination to `wr_imm[0]`.
- R8: Operation code 2 (sublane pattern) sets every lane of sublane s to `wr_imm[s]`, for s = 0..7.
- R9: Operation code 3 (AND) writes the bitwise AND of entries `wr_src_a` and `wr_src_b`. Both are 5-bit indices 0..31, and the sources are read before the edge.
- R10: Operation code 4 (NOT) writes the bitwise complement of entry `wr_src_a`, which is a 5-bit index 0..31.
- R11: Operation codes 5, 6 and 7 are refused: `wr_err` is high in that cycle and no entry changes.
- R12: While `wr_en` is low, `wr_err` stays low and no entry changes, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_id | input | 7 | Architectural id of the entry to read |
| rd_mask | output | 8·LANES | Mask of the addressed entry, or zero when the id is illegal |
| rd_illegal | output | 1 | Read id lies outside 0x5F..0x7E |
| wr_en | input | 1 | Write request |
| wr_op | input | 3 | Write source: 0 rectangle, 1 fill, 2 sublane pattern, 3 AND, 4 NOT |
| wr_id | input | 7 | Architectural id of the destination entry |
| wr_src_a | input | 5 | First source entry index for AND and NOT |
| wr_src_b | input | 5 | Second source entry index for AND |
| wr_imm | input | 32 | Rectangle bounds word, fill bit or sublane pattern |
| wr_err | output | 1 | Write request refused in this cycle |

## Verification
The bench targets four kinds of corner case.

- **Band edges.** It probes ids 0x5E, 0x6E, 0x6F, 0x7E and 0x7F on both ports. An off-by-one band check would either accept a write into the read-only upper half, so that a later readback shows a changed entry, or refuse a legal write to entry 15.
- **Rectangle bounds.** It uses single-cell, full, inverted (low above high) and lane-overflowing rectangles. A decoder that treated the high bounds as exclusive, or that swapped the interleaved fields, would show up in readback.
- **Read during write.** It reads an entry in the same cycle it is written. A write-through path would return the new value one cycle early.
- **AND and NOT sources.** It draws AND and NOT sources from the upper half of the file. A design that limited source indices to the write band would read the wrong entry.

// File: rtl/pmask_pkg.sv
package pmask_pkg;

    localparam int SUBLANES = 8;
    localparam int NREG     = 32;
    localparam int NWR      = 16;
    localparam int SEL_W    = $clog2(NREG);
    localparam int WSEL_W   = $clog2(NWR);
    localparam int ID_W     = 7;
    localparam int IMM_W    = 32;
    localparam int SB_W     = 3;
    localparam int LB_W     = 7;

    localparam logic [ID_W-1:0] ID_BASE   = 7'h5F;
    localparam logic [ID_W-1:0] ID_RD_TOP = ID_BASE + ID_W'(NREG - 1);
    localparam logic [ID_W-1:0] ID_WR_TOP = ID_BASE + ID_W'(NWR - 1);

    typedef enum logic [2:0] {
        OP_RECT = 3'd0,
        OP_FILL = 3'd1,
        OP_ROWS = 3'd2,
        OP_AND  = 3'd3,
        OP_NOT  = 3'd4
    } wop_e;

    // Inclusive rectangle bounds carried in the packed immediate word.
    typedef struct packed {
        logic [SB_W-1:0] s_lo;
        logic [SB_W-1:0] s_hi;
        logic [LB_W-1:0] l_lo;
        logic [LB_W-1:0] l_hi;
    } rect_t;

    function automatic rect_t rect_unpack(input logic [IMM_W-1:0] w);
        rect_t r;
        r.s_lo = w[2:0];
        r.l_lo = w[9:3];
        r.s_hi = w[12:10];
        r.l_hi = w[19:13];
        return r;
    endfunction

    function automatic logic id_in_band(input logic [ID_W-1:0] id,
                                        input logic [ID_W-1:0] top);
        return (id >= ID_BASE) && (id <= top);
    endfunction

endpackage

// File: rtl/pmask_rect_decode.sv
module pmask_rect_decode
    import pmask_pkg::*;
#(
    parameter int LANES = 16
) (
    input  rect_t                       rect,
    output logic [SUBLANES*LANES-1:0]   mask
);

    logic [SUBLANES-1:0] row_hit;
    logic [LANES-1:0]    col_hit;

    // Separate per-axis compares, then one AND per cell.
    for (genvar s = 0; s < SUBLANES; s++) begin : g_row
        localparam logic [SB_W-1:0] SIDX = SB_W'(s);
        assign row_hit[s] = (SIDX >= rect.s_lo) && (SIDX <= rect.s_hi);
    end

    for (genvar l = 0; l < LANES; l++) begin : g_col
        localparam logic [LB_W-1:0] LIDX = LB_W'(l);
        assign col_hit[l] = (LIDX >= rect.l_lo) && (LIDX <= rect.l_hi);
    end

    for (genvar s = 0; s < SUBLANES; s++) begin : g_cell_s
        for (genvar l = 0; l < LANES; l++) begin : g_cell_l
            assign mask[s*LANES + l] = row_hit[s] & col_hit[l];
        end
    end

endmodule

// File: rtl/pmask_src_gen.sv
module pmask_src_gen
    import pmask_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic [2:0]                  op,
    input  logic [IMM_W-1:0]            imm,
    input  logic [SUBLANES*LANES-1:0]   src_a,
    input  logic [SUBLANES*LANES-1:0]   src_b,
    output logic [SUBLANES*LANES-1:0]   data,
    output logic                        op_ok
);

    localparam int W = SUBLANES * LANES;

    logic [W-1:0] rect_mask;

    pmask_rect_decode #(.LANES(LANES)) rect_i (
        .rect (rect_unpack(imm)),
        .mask (rect_mask)
    );

    always_comb begin
        data  = '0;
        op_ok = 1'b1;
        case (wop_e'(op))
            OP_RECT: data = rect_mask;
            OP_FILL: data = {W{imm[0]}};
            OP_ROWS: begin
                for (int s = 0; s < SUBLANES; s++) begin
                    data[s*LANES +: LANES] = {LANES{imm[s]}};
                end
            end
            OP_AND:  data = src_a & src_b;
            OP_NOT:  data = ~src_a;
            default: op_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/pmask_store.sv
module pmask_store
    import pmask_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            we,
    input  logic [WSEL_W-1:0]               waddr,
    input  logic [SUBLANES*LANES-1:0]       wdata,
    input  logic [SEL_W-1:0]                raddr,
    output logic [SUBLANES*LANES-1:0]       rdata,
    input  logic [SEL_W-1:0]                aaddr,
    output logic [SUBLANES*LANES-1:0]       adata,
    input  logic [SEL_W-1:0]                baddr,
    output logic [SUBLANES*LANES-1:0]       bdata,
    output logic [NREG*SUBLANES*LANES-1:0]  flat
);

    localparam int W = SUBLANES * LANES;

    logic [W-1:0] mem_q [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[SEL_W'(waddr)] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
    assign adata = mem_q[aaddr];
    assign bdata = mem_q[baddr];

    for (genvar i = 0; i < NREG; i++) begin : g_flat
        assign flat[i*W +: W] = mem_q[i];
    end

endmodule

// File: rtl/pred_mask_file.sv
module pred_mask_file
    import pmask_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [6:0]                  rd_id,
    output logic [8*LANES-1:0]          rd_mask,
    output logic                        rd_illegal,
    input  logic                        wr_en,
    input  logic [2:0]                  wr_op,
    input  logic [6:0]                  wr_id,
    input  logic [4:0]                  wr_src_a,
    input  logic [4:0]                  wr_src_b,
    input  logic [31:0]                 wr_imm,
    output logic                        wr_err
);

    localparam int W = SUBLANES * LANES;

    logic               rd_ok;
    logic               wr_band_ok;
    logic               op_ok;
    logic               we;
    logic [SEL_W-1:0]   rd_idx;
    logic [WSEL_W-1:0]  wr_idx;
    logic [W-1:0]       rd_raw;
    logic [W-1:0]       a_data;
    logic [W-1:0]       b_data;
    logic [W-1:0]       w_data;
    logic [NREG*W-1:0]  file_flat;

    // Band checks on architectural ids.
    assign rd_ok      = id_in_band(rd_id, ID_RD_TOP);
    assign wr_band_ok = id_in_band(wr_id, ID_WR_TOP);
    assign rd_idx     = SEL_W'(rd_id - ID_BASE);
    assign wr_idx     = WSEL_W'(wr_id - ID_BASE);

    assign wr_err = wr_en & ~(wr_band_ok & op_ok);
    assign we     = wr_en & wr_band_ok & op_ok;

    pmask_src_gen #(.LANES(LANES)) src_i (
        .op    (wr_op),
        .imm   (wr_imm),
        .src_a (a_data),
        .src_b (b_data),
        .data  (w_data),
        .op_ok (op_ok)
    );

    pmask_store #(.LANES(LANES)) store_i (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .waddr (wr_idx),
        .wdata (w_data),
        .raddr (rd_idx),
        .rdata (rd_raw),
        .aaddr (wr_src_a),
        .adata (a_data),
        .baddr (wr_src_b),
        .bdata (b_data),
        .flat  (file_flat)
    );

    assign rd_illegal = ~rd_ok;
    assign rd_mask    = rd_ok ? rd_raw : '0;

endmodule

// File: rtl/pmask_chk.sv
module pmask_chk
    import pmask_pkg::*;
#(
    parameter int LANES = 16
) (
    input logic                             clk,
    input logic                             rst,
    input logic [6:0]                       rd_id,
    input logic [SUBLANES*LANES-1:0]        rd_mask,
    input logic                             rd_illegal,
    input logic                             wr_en,
    input logic [2:0]                       wr_op,
    input logic [6:0]                       wr_id,
    input logic [4:0]                       wr_src_a,
    input logic [31:0]                      wr_imm,
    input logic                             wr_err,
    input logic [NREG*SUBLANES*LANES-1:0]   file_flat
);

    localparam int W = SUBLANES * LANES;

    logic [3:0]   widx;
    logic [W-1:0] src_a_val;
    logic         accepted;

    assign widx      = 4'(wr_id - ID_BASE);
    assign src_a_val = file_flat[int'(wr_src_a)*W +: W];
    assign accepted  = wr_en && !wr_err;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> file_flat == '0);

    // R2
    rd_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_id < 7'h5F || rd_id > 7'h7E) |-> (rd_illegal && rd_mask == '0));

    // R2
    rd_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_id >= 7'h5F && rd_id <= 7'h7E) |-> !rd_illegal);

    // R3
    wr_band_err_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_id < 7'h5F || wr_id > 7'h6E)) |-> wr_err);

    // R3
    reject_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_err) |=> $stable(file_flat));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(file_flat) && !$past(wr_err)));

    // R7
    fill_value_chk: assert property (@(posedge clk) disable iff (rst)
        (accepted && wr_op == 3'd1) |=>
            file_flat[int'($past(widx))*W +: W] == {W{$past(wr_imm[0])}});

    // R10
    not_value_chk: assert property (@(posedge clk) disable iff (rst)
        (accepted && wr_op == 3'd4) |=>
            file_flat[int'($past(widx))*W +: W] == ~$past(src_a_val));

endmodule

bind pred_mask_file pmask_chk #(.LANES(LANES)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .rd_id      (rd_id),
    .rd_mask    (rd_mask),
    .rd_illegal (rd_illegal),
    .wr_en      (wr_en),
    .wr_op      (wr_op),
    .wr_id      (wr_id),
    .wr_src_a   (wr_src_a),
    .wr_imm     (wr_imm),
    .wr_err     (wr_err),
    .file_flat  (file_flat)
);

// File: tb/pred_mask_file_tb_top.sv
module pred_mask_file_tb_top;

    localparam int CLK_P = 10;
    localparam int LANES = 16;
    localparam int SUBL  = 8;
    localparam int W     = SUBL * LANES;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [6:0]   rd_id = '0;
    logic [W-1:0] rd_mask;
    logic         rd_illegal;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_op = '0;
    logic [6:0]   wr_id = '0;
    logic [4:0]   wr_src_a = '0;
    logic [4:0]   wr_src_b = '0;
    logic [31:0]  wr_imm = '0;
    logic         wr_err;

    int checks = 0;
    int failures = 0;

    logic [W-1:0] mdl [32];

    always #(CLK_P/2) clk = ~clk;

    pred_mask_file #(.LANES(LANES)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .rd_id      (rd_id),
        .rd_mask    (rd_mask),
        .rd_illegal (rd_illegal),
        .wr_en      (wr_en),
        .wr_op      (wr_op),
        .wr_id      (wr_id),
        .wr_src_a   (wr_src_a),
        .wr_src_b   (wr_src_b),
        .wr_imm     (wr_imm),
        .wr_err     (wr_err)
    );

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rect_word(int slo, int shi, int llo, int lhi);
        return 32'(slo) | (32'(llo) << 3) | (32'(shi) << 10) | (32'(lhi) << 13);
    endfunction

    // Behavioural expectation for the write data.
    function automatic logic [W-1:0] model_data(int op, logic [31:0] imm, int sa, int sb);
        logic [W-1:0] d = '0;
        int slo = int'(imm[2:0]);
        int llo = int'(imm[9:3]);
        int shi = int'(imm[12:10]);
        int lhi = int'(imm[19:13]);
        for (int s = 0; s < SUBL; s++) begin
            for (int l = 0; l < LANES; l++) begin
                case (op)
                    0: d[s*LANES+l] = (s >= slo && s <= shi && l >= llo && l <= lhi);
                    1: d[s*LANES+l] = imm[0];
                    2: d[s*LANES+l] = imm[s];
                    3: d[s*LANES+l] = mdl[sa][s*LANES+l] & mdl[sb][s*LANES+l];
                    4: d[s*LANES+l] = ~mdl[sa][s*LANES+l];
                    default: d[s*LANES+l] = 1'b0;
                endcase
            end
        end
        return d;
    endfunction

    task automatic cyc(input logic en, input int op, input int id, input int sa,
                       input int sb, input logic [31:0] imm, input int rid,
                       input string req);
        logic         exp_err;
        logic         rlegal;
        logic [W-1:0] exp_rd;
        logic [W-1:0] nd;
        @(negedge clk);
        wr_en = en; wr_op = 3'(op); wr_id = 7'(id); wr_src_a = 5'(sa);
        wr_src_b = 5'(sb); wr_imm = imm; rd_id = 7'(rid);
        #1;
        rlegal  = (rid >= 'h5F && rid <= 'h7E);
        exp_rd  = rlegal ? mdl[rid - 'h5F] : '0;
        exp_err = en && !(id >= 'h5F && id <= 'h6E && op <= 4);
        nd      = model_data(op, imm, sa, sb);
        check(req, "rd_mask", rd_mask, exp_rd);
        check(req, "rd_illegal", W'(rd_illegal), W'(!rlegal));
        check(req, "wr_err", W'(wr_err), W'(exp_err));
        @(posedge clk);
        if (en && !exp_err) mdl[id - 'h5F] = nd;
    endtask

    task automatic idle_read(input int rid, input string req);
        cyc(1'b0, 0, 'h5F, 0, 0, 32'h0, rid, req);
    endtask

    task automatic read_all(input string req);
        for (int i = 'h5F; i <= 'h7E; i++) idle_read(i, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0;
        @(posedge clk);
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: all entries clear after reset
        read_all("R1");

        // R7: uniform fills
        cyc(1'b1, 1, 'h5F, 0, 0, 32'h1, 'h5F, "R7");
        idle_read('h5F, "R7");
        cyc(1'b1, 1, 'h60, 0, 0, 32'h1, 'h60, "R7");
        cyc(1'b1, 1, 'h60, 0, 0, 32'hFFFF_FFFE, 'h60, "R7");
        idle_read('h60, "R7");

        // R8: sublane pattern
        cyc(1'b1, 2, 'h61, 0, 0, 32'hFFFF_FFA5, 'h61, "R8");
        idle_read('h61, "R8");

        // R6 / R5: rectangles
        cyc(1'b1, 0, 'h62, 0, 0, rect_word(1, 5, 2, 9), 'h62, "R6");
        idle_read('h62, "R5");
        cyc(1'b1, 0, 'h63, 0, 0, rect_word(0, 7, 0, 127), 'h63, "R6");
        idle_read('h63, "R6");
        cyc(1'b1, 0, 'h64, 0, 0, rect_word(5, 2, 0, 15), 'h64, "R6");
        idle_read('h64, "R6");
        cyc(1'b1, 0, 'h65, 0, 0, rect_word(3, 3, 12, 127), 'h65, "R6");
        idle_read('h65, "R6");
        cyc(1'b1, 0, 'h66, 0, 0, rect_word(7, 7, 15, 15), 'h66, "R5");
        idle_read('h66, "R5");

        // R9: AND of two stored masks
        cyc(1'b1, 3, 'h67, 2, 3, 32'h0, 'h5F, "R9");
        idle_read('h67, "R9");
        // R10: NOT, including a source in the upper half
        cyc(1'b1, 4, 'h68, 3, 0, 32'h0, 'h5F, "R10");
        idle_read('h68, "R10");
        cyc(1'b1, 4, 'h69, 20, 0, 32'h0, 'h5F, "R10");
        idle_read('h69, "R10");
        cyc(1'b1, 3, 'h6A, 9, 31, 32'h0, 'h5F, "R9");
        idle_read('h6A, "R9");

        // R4: read during write returns old value, then new value
        cyc(1'b1, 1, 'h6B, 0, 0, 32'h1, 'h6B, "R4");
        idle_read('h6B, "R4");
        cyc(1'b1, 1, 'h6B, 0, 0, 32'h0, 'h6B, "R4");
        idle_read('h6B, "R4");

        // R3: writes outside the band refused
        cyc(1'b1, 1, 'h6E, 0, 0, 32'h1, 'h6E, "R3");
        cyc(1'b1, 1, 'h6F, 0, 0, 32'h1, 'h6F, "R3");
        cyc(1'b1, 1, 'h7E, 0, 0, 32'h1, 'h7E, "R3");
        cyc(1'b1, 1, 'h5E, 0, 0, 32'h1, 'h5F, "R3");
        cyc(1'b1, 4, 'h00, 0, 0, 32'h1, 'h6F, "R3");
        read_all("R3");

        // R11: unknown operation codes refused
        cyc(1'b1, 5, 'h60, 0, 0, 32'hFFFF_FFFF, 'h60, "R11");
        cyc(1'b1, 6, 'h61, 0, 0, 32'hFFFF_FFFF, 'h61, "R11");
        cyc(1'b1, 7, 'h62, 0, 0, 32'hFFFF_FFFF, 'h62, "R11");
        idle_read('h60, "R11");
        idle_read('h61, "R11");
        idle_read('h62, "R11");

        // R2: illegal read ids
        idle_read('h5E, "R2");
        idle_read('h7F, "R2");
        idle_read('h00, "R2");
        idle_read('h7E, "R2");

        // R12: idle cycles with busy write inputs
        for (int i = 0; i < 8; i++)
            cyc(1'b0, i % 5, 'h5F + i, i, 31 - i, 32'hFFFF_FFFF, 'h5F + i, "R12");
        read_all("R12");

        // Mixed traffic
        for (int i = 0; i < 400; i++) begin
            cyc(1'($urandom % 4 != 0), int'($urandom % 8), 'h58 + int'($urandom % 40),
                int'($urandom % 32), int'($urandom % 32), $urandom,
                'h58 + int'($urandom % 44), "R2");
        end
        read_all("R9");

        // R1: reset in mid-run
        do_reset();
        read_all("R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule